// File: doc/BRIEF.md
# Boot Mode Latch and Signature Checker

This block decides how a device comes out of hardware reset. While reset is held it samples a 2-bit configuration from input pins. It keeps the last sampled value and decodes it into one of four modes: alternate boot, standard bootstrap, normal operation, or a reserved test mode. The test mode is flagged and has no further effect.

When alternate boot is selected, a small sequencer reads three 16-bit words through a synchronous memory read port. The first two words are added and the low byte of the sum is inverted. The result is then compared with the third word. A match marks the signature valid, and the block drives the alternate code start address. Any other outcome drives the standard vector.

A read-only status register holds the alternate-boot flag, so boot software can test it. A software reset pulse samples the pins again and restarts the sequence.

Top module: `bootsig_guard`

## Requirements
- R1: While `rst_n` is low, `cfg_pins` is sampled on every clock edge. The value sampled at the last edge of reset is held afterwards, and pin changes after reset release have no effect on the mode outputs.
- R2: The held code decodes as follows: 2'b01 sets `mode_alt`, 2'b10 sets `mode_std`, 2'b11 sets `mode_norm` and 2'b00 sets `mode_test`. Exactly one of the four mode outputs is high.
- R3: A read with `reg_rd_en` high at `reg_addr` 16'hFE0A returns, one cycle later on `reg_rdata`, the alternate-boot flag in bit 5 with every other bit 0. A read at any other offset returns 16'h0000.
- R4: The alternate-boot flag cannot be changed through the register port. It changes only at a reset or when `sw_rst` is high for an edge. That edge samples `cfg_pins` again and returns the sequencer to idle, even in the middle of a check.
- R5: In alternate boot mode the sequencer reads byte addresses 24'h000000, 24'h001FFC and 24'h001FFE, in that order. It requests one address per cycle, so `mem_req` is high for exactly three cycles. `mem_rdata` is taken one cycle after each request.
- R6: The two first words are added modulo 2^16 with the carry dropped. Bits 7:0 of the sum are inverted and bits 15:8 are kept. If the result equals the third word, `sig_ok` is set; otherwise `sig_bad` is set. The two are never high together.
- R7: `start_addr` is 24'h090000 while `sig_ok` is high, and 24'h000000 otherwise.
- R8: After reset release or an `sw_rst` edge, `boot_ready` rises on the 5th clock edge in alternate boot mode and on the 1st edge in every other mode, and then stays high. Non-alternate modes issue no memory reads and leave `sig_ok` and `sig_bad` low.
- R9: While `rst_n` is low, `boot_ready`, `mem_req`, `sig_ok`, `sig_bad` and `reg_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset; pins are sampled while low |
| sw_rst | input | 1 | Software reset pulse: sample pins again, restart sequence |
| cfg_pins | input | 2 | Boot configuration pins |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 24 | Memory read byte address |
| mem_rdata | input | 16 | Read data, valid one cycle after request |
| reg_rd_en | input | 1 | Status register read strobe |
| reg_addr | input | 16 | Register offset for the read |
| reg_rdata | output | 16 | Registered read data |
| mode_alt | output | 1 | Alternate boot selected |
| mode_std | output | 1 | Standard bootstrap selected |
| mode_norm | output | 1 | Normal operation selected |
| mode_test | output | 1 | Reserved test code seen |
| boot_ready | output | 1 | Boot decision final |
| sig_ok | output | 1 | Signature matched |
| sig_bad | output | 1 | Signature mismatched |
| start_addr | output | 24 | Code start address |

## Verification
Two functions can meet in one cycle: a status register read and the final compare step of the sequencer. The bench raises `reg_rd_en` at offset FE0Ah so that its edge is the same edge on which the compare result is registered. On that edge it expects `boot_ready`, `sig_ok` and the flag word 16'h0020 together. A second collision is a software reset that lands while reads are still in progress. It is judged by the mode taken from the new pins, a ready after one edge, and a clean `sig_ok` and `sig_bad`.

// File: rtl/bootsig_pkg.sv
// Shared types for the boot mode latch and signature checker.
// Assumes a 2-bit configuration code and a six-state read sequencer.
package bootsig_pkg;
    localparam int CFG_W = 2;

    typedef enum logic [CFG_W-1:0] {
        CFG_TEST = 2'b00,
        CFG_ALT  = 2'b01,
        CFG_STD  = 2'b10,
        CFG_NORM = 2'b11
    } cfg_code_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_RD1,
        SQ_RD2,
        SQ_RD3,
        SQ_CMP,
        SQ_DONE
    } seq_state_e;

    typedef struct packed {
        logic alt;
        logic std;
        logic norm;
        logic test;
    } mode_t;
endpackage

// File: rtl/bootsig_cfg_latch.sv
// Samples the boot pins while reset (or a software reset) is active,
// holds the code afterwards and decodes it into one-hot mode flags.
// Assumes the pins are stable around the last reset edge.
module bootsig_cfg_latch
    import bootsig_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_rst,
    input  logic [CFG_W-1:0] pins,
    output mode_t            mode
);
    cfg_code_e code_q;

    // Capture pins during any reset, hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            code_q <= cfg_code_e'(pins);
        end
    end

    // Map the held code onto one mode flag.
    always_comb begin
        mode = '0;
        unique case (code_q)
            CFG_ALT:  mode.alt  = 1'b1;
            CFG_STD:  mode.std  = 1'b1;
            CFG_NORM: mode.norm = 1'b1;
            default:  mode.test = 1'b1;
        endcase
    end
endmodule

// File: rtl/bootsig_seq.sv
// Signature sequencer: reads three words, adds the first two (carry dropped),
// inverts the low INV_W bits of the sum and compares with the third word.
// Assumes read data arrives exactly one cycle after each request.
module bootsig_seq
    import bootsig_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int INV_W  = 8,
    parameter logic [ADDR_W-1:0] CHK_A = 24'h000000,
    parameter logic [ADDR_W-1:0] CHK_B = 24'h001FFC,
    parameter logic [ADDR_W-1:0] CHK_C = 24'h001FFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              alt_sel,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ready,
    output logic              ok,
    output logic              bad
);
    localparam int KEEP_W = DATA_W - INV_W;

    seq_state_e        state_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] sig_w;

    // Low bits inverted, upper bits passed through.
    assign sig_w = {acc_q[DATA_W-1:INV_W], ~acc_q[INV_W-1:0]};

    // Step through the three reads and the compare.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            state_q <= SQ_IDLE;
            acc_q   <= '0;
            ok      <= 1'b0;
            bad     <= 1'b0;
        end else begin
            unique case (state_q)
                SQ_IDLE: state_q <= alt_sel ? SQ_RD1 : SQ_DONE;
                SQ_RD1:  state_q <= SQ_RD2;
                SQ_RD2: begin
                    acc_q   <= mem_rdata;
                    state_q <= SQ_RD3;
                end
                SQ_RD3: begin
                    acc_q   <= acc_q + mem_rdata;
                    state_q <= SQ_CMP;
                end
                SQ_CMP: begin
                    ok      <= (sig_w == mem_rdata);
                    bad     <= (sig_w != mem_rdata);
                    state_q <= SQ_DONE;
                end
                default: state_q <= SQ_DONE;
            endcase
        end
    end

    // Request and address for the state's read.
    always_comb begin
        mem_req  = 1'b1;
        mem_addr = '0;
        unique case (state_q)
            SQ_RD1:  mem_addr = CHK_A;
            SQ_RD2:  mem_addr = CHK_B;
            SQ_RD3:  mem_addr = CHK_C;
            default: mem_req  = 1'b0;
        endcase
    end

    assign ready = (state_q == SQ_DONE);

    // Width sanity: a split with no kept bits is not supported.
    initial begin
        if (KEEP_W < 1) $display("bootsig_seq: INV_W must be below DATA_W");
    end
endmodule

// File: rtl/bootsig_statreg.sv
// Read-only status register: one flag bit at FLAG_BIT, rest zero.
// Registered read, one cycle latency; unmatched offsets read zero.
module bootsig_statreg #(
    parameter int REG_AW   = 16,
    parameter int DATA_W   = 16,
    parameter int FLAG_BIT = 5,
    parameter logic [REG_AW-1:0] REG_OFS = 16'hFE0A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] word_w;

    // Place the flag at its bit, tie the rest low.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == FLAG_BIT) begin : g_flag
            assign word_w[i] = flag;
        end else begin : g_zero
            assign word_w[i] = 1'b0;
        end
    end

    // Return the register word on a matching read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= (rd_addr == REG_OFS) ? word_w : '0;
        end
    end
endmodule

// File: rtl/bootsig_guard.sv
// Top: boot configuration latch, signature sequencer and status register.
// Start address selects the alternate vector only after a matched signature.
module bootsig_guard
    import bootsig_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int REG_AW = 16,
    parameter logic [ADDR_W-1:0] ALT_VEC = 24'h090000,
    parameter logic [ADDR_W-1:0] STD_VEC = 24'h000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic [1:0]        cfg_pins,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              reg_rd_en,
    input  logic [REG_AW-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mode_alt,
    output logic              mode_std,
    output logic              mode_norm,
    output logic              mode_test,
    output logic              boot_ready,
    output logic              sig_ok,
    output logic              sig_bad,
    output logic [ADDR_W-1:0] start_addr
);
    mode_t mode_w;

    bootsig_cfg_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_rst (sw_rst),
        .pins   (cfg_pins),
        .mode   (mode_w)
    );

    bootsig_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_rst    (sw_rst),
        .alt_sel   (mode_w.alt),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .ready     (boot_ready),
        .ok        (sig_ok),
        .bad       (sig_bad)
    );

    bootsig_statreg #(
        .REG_AW (REG_AW),
        .DATA_W (DATA_W)
    ) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .flag    (mode_w.alt),
        .rd_en   (reg_rd_en),
        .rd_addr (reg_addr),
        .rd_data (reg_rdata)
    );

    assign mode_alt   = mode_w.alt;
    assign mode_std   = mode_w.std;
    assign mode_norm  = mode_w.norm;
    assign mode_test  = mode_w.test;
    assign start_addr = sig_ok ? ALT_VEC : STD_VEC;
endmodule

// File: rtl/bootsig_guard_chk.sv
// Assertion checker for bootsig_guard, attached by bind below.
module bootsig_guard_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sw_rst,
    input logic        mem_req,
    input logic [15:0] reg_rdata,
    input logic        mode_alt,
    input logic        boot_ready,
    input logic        sig_ok,
    input logic        sig_bad,
    input logic [23:0] start_addr
);
    // R4
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_rst |=> $stable(mode_alt));
    // R8
    req_only_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mode_alt && !boot_ready);
    // R6
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sig_ok && sig_bad));
    // R6
    verdict_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sig_ok) |-> $past(mem_req, 2));
    // R7
    vector_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_addr != 24'h000000) |-> sig_ok);
    // R8
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_ready && !sw_rst) |=> boot_ready);
    // R3
    reg_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & 16'hFFDF) == 16'h0000);
endmodule

bind bootsig_guard bootsig_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_rst     (sw_rst),
    .mem_req    (mem_req),
    .reg_rdata  (reg_rdata),
    .mode_alt   (mode_alt),
    .boot_ready (boot_ready),
    .sig_ok     (sig_ok),
    .sig_bad    (sig_bad),
    .start_addr (start_addr)
);

// File: tb/bootsig_guard_bench.sv
`timescale 1ns/1ps
module bootsig_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_rst = 1'b0;
    logic [1:0]  cfg_pins = 2'b00;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic [15:0] mem_rdata = 16'h0000;
    logic        reg_rd_en = 1'b0;
    logic [15:0] reg_addr = 16'h0000;
    logic [15:0] reg_rdata;
    logic        mode_alt, mode_std, mode_norm, mode_test;
    logic        boot_ready, sig_ok, sig_bad;
    logic [23:0] start_addr;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [15:0] w1, w2, w3;
    int          rd_cnt;
    logic [23:0] rd_log [0:3];

    always #2 clk = ~clk;

    bootsig_guard u_bootsig_guard (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cfg_pins(cfg_pins),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .reg_rd_en(reg_rd_en), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
        .mode_alt(mode_alt), .mode_std(mode_std), .mode_norm(mode_norm),
        .mode_test(mode_test), .boot_ready(boot_ready), .sig_ok(sig_ok),
        .sig_bad(sig_bad), .start_addr(start_addr)
    );

    // Synchronous memory model with a read log.
    always @(posedge clk) begin
        if (mem_req) begin
            case (mem_addr)
                24'h000000: mem_rdata <= w1;
                24'h001FFC: mem_rdata <= w2;
                24'h001FFE: mem_rdata <= w3;
                default:    mem_rdata <= 16'hDEAD;
            endcase
            if (rd_cnt < 4) rd_log[rd_cnt] <= mem_addr;
            rd_cnt = rd_cnt + 1;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic read_reg(input logic [15:0] ofs, output logic [15:0] val);
        reg_rd_en = 1'b1;
        reg_addr  = ofs;
        step();
        reg_rd_en = 1'b0;
        val = reg_rdata;
    endtask

    task automatic hard_reset(input logic [1:0] cfg);
        rst_n = 1'b0;
        sw_rst = 1'b0;
        cfg_pins = cfg;
        repeat (3) step();
        rd_cnt = 0;
    endtask

    function automatic int wait_ready();
        return 0;
    endfunction

    // {cfg, w1, w2, w3, mode{alt,std,norm,test}, pass}
    localparam logic [54:0] VECS [0:6] = '{
        {2'b01, 16'h1234, 16'h1111, 16'h23BA, 4'b1000, 1'b1},
        {2'b01, 16'hFFFF, 16'h0002, 16'h00FE, 4'b1000, 1'b1},
        {2'b01, 16'h1234, 16'h1111, 16'h2345, 4'b1000, 1'b0},
        {2'b01, 16'h8000, 16'h8000, 16'hFFFF, 4'b1000, 1'b0},
        {2'b10, 16'h1234, 16'h1111, 16'h23BA, 4'b0100, 1'b0},
        {2'b11, 16'h1234, 16'h1111, 16'h23BA, 4'b0010, 1'b0},
        {2'b00, 16'h1234, 16'h1111, 16'h23BA, 4'b0001, 1'b0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] rv;
        int n;
        rd_cnt = 0;
        w1 = 16'h0; w2 = 16'h0; w3 = 16'h0;

        // Vector table walk.
        for (int v = 0; v < 7; v++) begin
            logic [1:0] cfg;
            logic [3:0] emode;
            logic       epass, ealt;
            cfg   = VECS[v][54:53];
            w1    = VECS[v][52:37];
            w2    = VECS[v][36:21];
            w3    = VECS[v][20:5];
            emode = VECS[v][4:1];
            epass = VECS[v][0];
            ealt  = emode[3];
            hard_reset(cfg);
            // R9: outputs quiet during reset
            check(!boot_ready && !mem_req && !sig_ok && !sig_bad && reg_rdata == 16'h0,
                  "R9 reset outputs", {boot_ready, mem_req, sig_ok, sig_bad}, 0);
            rst_n = 1'b1;
            cfg_pins = ~cfg;
            n = 0;
            for (int k = 1; k <= 10; k++) begin
                step();
                if (boot_ready && n == 0) n = k;
            end
            // R8: ready timing
            check(n == (ealt ? 5 : 1), "R8 ready edge", n, ealt ? 5 : 1);
            // R1, R2: mode from pins sampled in reset
            check({mode_alt, mode_std, mode_norm, mode_test} == emode,
                  "R1 R2 mode decode", {mode_alt, mode_std, mode_norm, mode_test}, emode);
            // R6: verdict
            check(sig_ok == epass && sig_bad == (ealt && !epass), "R6 verdict",
                  {sig_ok, sig_bad}, {epass, ealt && !epass});
            // R7: start address
            check(start_addr == (epass ? 24'h090000 : 24'h000000), "R7 start address",
                  start_addr, epass ? 24'h090000 : 24'h000000);
            // R5: read count and order
            check(rd_cnt == (ealt ? 3 : 0), "R5 read count", rd_cnt, ealt ? 3 : 0);
            if (ealt) begin
                check(rd_log[0] == 24'h000000 && rd_log[1] == 24'h001FFC && rd_log[2] == 24'h001FFE,
                      "R5 read order", rd_log[1], 24'h001FFC);
            end
            // R3: status register
            read_reg(16'hFE0A, rv);
            check(rv == (ealt ? 16'h0020 : 16'h0000), "R3 status read", rv, ealt ? 16'h0020 : 16'h0000);
        end

        // R3: other offset reads zero with flag set
        w1 = 16'h1234; w2 = 16'h1111; w3 = 16'h23BA;
        hard_reset(2'b01);
        rst_n = 1'b1;
        repeat (4) step();
        // Same-cycle: register read on the compare edge.
        reg_rd_en = 1'b1;
        reg_addr  = 16'hFE0A;
        step();
        reg_rd_en = 1'b0;
        check(boot_ready && sig_ok && reg_rdata == 16'h0020, "R3 R8 read on compare edge",
              {boot_ready, sig_ok, reg_rdata}, {1'b1, 1'b1, 16'h0020});
        read_reg(16'hFE08, rv);
        check(rv == 16'h0000, "R3 other offset", rv, 16'h0000);

        // R4: flag unchanged by activity, cleared by software reset with new pins
        cfg_pins = 2'b10;
        repeat (3) step();
        check(mode_alt == 1'b1, "R4 flag holds", mode_alt, 1);
        sw_rst = 1'b1;
        step();
        sw_rst = 1'b0;
        cfg_pins = 2'b01;
        check(mode_std && !mode_alt && !boot_ready && !sig_ok, "R4 sw reset resample",
              {mode_alt, mode_std, boot_ready, sig_ok}, 4'b0100);
        step();
        check(boot_ready && start_addr == 24'h000000, "R8 std after sw reset", start_addr, 0);
        read_reg(16'hFE0A, rv);
        check(rv == 16'h0000, "R4 flag cleared", rv, 0);

        // R4: software reset back to alternate reruns the check
        sw_rst = 1'b1;
        rd_cnt = 0;
        step();
        sw_rst = 1'b0;
        repeat (5) step();
        check(boot_ready && sig_ok && rd_cnt == 3, "R4 rerun after sw reset", rd_cnt, 3);

        // R4: software reset in the middle of the reads
        sw_rst = 1'b1;
        step();
        sw_rst = 1'b0;
        repeat (2) step();
        cfg_pins = 2'b11;
        sw_rst = 1'b1;
        step();
        sw_rst = 1'b0;
        step();
        check(mode_norm && boot_ready && !sig_ok && !sig_bad && start_addr == 24'h0,
              "R4 sw reset mid check", {mode_norm, boot_ready, sig_ok, sig_bad}, 4'b1100);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule